// File: doc/BRIEF.md
# USB PHY Power-Up Sequencer

This block brings a two-port USB 2.0 PHY out of power-down and puts it back again. When software or a boot controller raises an init request, the sequencer first switches on the PHY reference clock. After that clock has settled, it lifts the PHY power-on reset. It then programs the PHY clock-enable control register through the PHY's serial test-register port. Finally, it releases the UTMI reset of the port chosen at request time. Each step is followed by a settling interval measured in microseconds. Every interval is turned into an exact number of system-clock cycles from a cycles-per-microsecond parameter.

An exit request tears the PHY down in the reverse order: the UTMI resets first, then the power-on reset, and the reference clock last, one step per cycle. The `busy` output is high while either sequence runs. The `done` output is high once the PHY is fully up and stays high until an exit begins. Requests that arrive at an unsuitable time are dropped rather than queued.

Top module: `usbphy_bringup_seq`

## Requirements
- R1: During and after synchronous reset, `refclk_en` is 0, `por_rst` is 1, every bit of `utmi_rst` is 1, `tst_wren`, `tst_clk`, `tst_addr`, `tst_data`, `busy` and `done` are 0.
- R2: An init request accepted in the powered-down idle state sets `refclk_en` and `busy` at the accepting edge. `por_rst` falls exactly REF_US×CYCLES_PER_US cycles later, and never while `refclk_en` is low.
- R3: Exactly POR_US×CYCLES_PER_US cycles after `por_rst` falls, the test port presents a write: `tst_wren`=1, `tst_addr`=0x06, `tst_data`=0x04 (bit 2 = PHY clock enable), `tst_clk`=0.
- R4: The write strobe has three phases of one cycle each: `tst_clk` low, high, low. Address, data and `tst_wren` are held through all three phases and cleared together on the following cycle.
- R5: PHYCLK_US×CYCLES_PER_US cycles after the write fields clear, the `utmi_rst` bit of the port latched from `port_sel` at init (bit index = port number) goes low. The other port stays in reset, and no UTMI reset is released while `por_rst` is high.
- R6: UTMI_US×CYCLES_PER_US cycles after the UTMI release, `done` rises and `busy` falls on the same edge. `done` and `busy` are never high together.
- R7: An accepted exit request sets every `utmi_rst` bit, clears `done` and sets `busy` at the accepting edge. `por_rst` rises one cycle later. `refclk_en` falls and `busy` clears one cycle after that.
- R8: Init and exit requests raised while `busy` is high have no effect on any output.
- R9: An init request while `done` is high is ignored. When init and exit are raised together, the exit is served.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| init_req | input | 1 | Start the power-up sequence (sampled each cycle) |
| exit_req | input | 1 | Start the power-down sequence |
| port_sel | input | PSW | Port whose UTMI reset the init releases |
| refclk_en | output | 1 | PHY reference clock enable |
| por_rst | output | 1 | PHY power-on reset, active high |
| utmi_rst | output | NPORT | Per-port UTMI reset, active high |
| tst_addr | output | 8 | Test-port register address |
| tst_data | output | 8 | Test-port write data |
| tst_wren | output | 1 | Test-port write enable |
| tst_clk | output | 1 | Test-port strobe, rising edge writes |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | PHY is fully powered up |

## Verification
The power-up is run once for each port. This shows whether the port index is latched correctly and that the other port's reset is left asserted. The full set of output edges is compared at the exact cycles the settling intervals predict, so an off-by-one in any single interval shows up on its own. Stray init and exit pulses are injected mid-sequence, after completion, and together in one cycle. These show the difference between a request that is dropped and one that is wrongly queued or served. Exits are issued both from the powered-up state and from the already-idle state: the first exercises the full reverse order, the second leaves only the `busy` pulse visible.

// File: rtl/usbphy_seq_pkg.sv
package usbphy_seq_pkg;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_REF_WAIT,
    ST_POR_WAIT,
    ST_WR_SETUP,
    ST_WR_HIGH,
    ST_WR_LOW,
    ST_PHY_WAIT,
    ST_UTMI_WAIT,
    ST_UP,
    ST_DN_POR,
    ST_DN_REF
  } seq_state_e;

  localparam logic [7:0] CLKCTL_ADDR = 8'h06;
  localparam logic [7:0] CLKCTL_DATA = 8'h04;

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/utmi_rst_bank.sv
module utmi_rst_bank #(
  parameter int NPORT = 2,
  parameter int PSW   = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_all,
  input  logic             rel_en,
  input  logic [PSW-1:0]   rel_idx,
  output logic [NPORT-1:0] rst_q
);

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst || set_all) begin
        rst_q[i] <= 1'b1;
      end else if (rel_en && (rel_idx == PSW'(i))) begin
        rst_q[i] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/usbphy_bringup_seq.sv
module usbphy_bringup_seq
  import usbphy_seq_pkg::*;
#(
  parameter int CYCLES_PER_US = 200,
  parameter int REF_US        = 100,
  parameter int POR_US        = 300,
  parameter int PHYCLK_US     = 2000,
  parameter int UTMI_US       = 2000,
  parameter int NPORT         = 2,
  parameter int PSW           = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init_req,
  input  logic             exit_req,
  input  logic [PSW-1:0]   port_sel,
  output logic             refclk_en,
  output logic             por_rst,
  output logic [NPORT-1:0] utmi_rst,
  output logic [7:0]       tst_addr,
  output logic [7:0]       tst_data,
  output logic             tst_wren,
  output logic             tst_clk,
  output logic             busy,
  output logic             done
);

  localparam int D_REF  = REF_US * CYCLES_PER_US;
  localparam int D_POR  = POR_US * CYCLES_PER_US;
  localparam int D_PHY  = PHYCLK_US * CYCLES_PER_US;
  localparam int D_UTMI = UTMI_US * CYCLES_PER_US;
  localparam int M_A    = (D_REF > D_POR) ? D_REF : D_POR;
  localparam int M_B    = (D_PHY > D_UTMI) ? D_PHY : D_UTMI;
  localparam int D_MAX  = (M_A > M_B) ? M_A : M_B;
  localparam int CW     = $clog2(D_MAX + 1);

  seq_state_e     state;
  logic [PSW-1:0] port_q;
  logic           t_load;
  logic [CW-1:0]  t_val;
  logic           t_zero;
  logic           idle_ok;
  logic           go_down;
  logic           go_up;
  logic           utmi_rel;

  assign idle_ok  = (state == ST_OFF) || (state == ST_UP);
  assign go_down  = idle_ok && exit_req;
  assign go_up    = (state == ST_OFF) && init_req && !exit_req;
  assign utmi_rel = (state == ST_PHY_WAIT) && t_zero;

  always_comb begin
    t_load = 1'b0;
    t_val  = '0;
    if (go_up) begin
      t_load = 1'b1;
      t_val  = CW'(D_REF - 1);
    end else if ((state == ST_REF_WAIT) && t_zero) begin
      t_load = 1'b1;
      t_val  = CW'(D_POR - 1);
    end else if (state == ST_WR_LOW) begin
      t_load = 1'b1;
      t_val  = CW'(D_PHY - 1);
    end else if (utmi_rel) begin
      t_load = 1'b1;
      t_val  = CW'(D_UTMI - 1);
    end
  end

  seq_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .zero     (t_zero)
  );

  utmi_rst_bank #(.NPORT(NPORT), .PSW(PSW)) u_utmi (
    .clk     (clk),
    .rst     (rst),
    .set_all (go_down),
    .rel_en  (utmi_rel),
    .rel_idx (port_q),
    .rst_q   (utmi_rst)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_OFF;
      port_q    <= '0;
      refclk_en <= 1'b0;
      por_rst   <= 1'b1;
      tst_addr  <= '0;
      tst_data  <= '0;
      tst_wren  <= 1'b0;
      tst_clk   <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      case (state)
        ST_OFF, ST_UP: begin
          if (go_down) begin
            state <= ST_DN_POR;
            busy  <= 1'b1;
            done  <= 1'b0;
          end else if (go_up) begin
            state     <= ST_REF_WAIT;
            port_q    <= port_sel;
            refclk_en <= 1'b1;
            busy      <= 1'b1;
          end
        end
        ST_REF_WAIT: begin
          if (t_zero) begin
            state   <= ST_POR_WAIT;
            por_rst <= 1'b0;
          end
        end
        ST_POR_WAIT: begin
          if (t_zero) begin
            state    <= ST_WR_SETUP;
            tst_wren <= 1'b1;
            tst_addr <= CLKCTL_ADDR;
            tst_data <= CLKCTL_DATA;
          end
        end
        ST_WR_SETUP: begin
          state   <= ST_WR_HIGH;
          tst_clk <= 1'b1;
        end
        ST_WR_HIGH: begin
          state   <= ST_WR_LOW;
          tst_clk <= 1'b0;
        end
        ST_WR_LOW: begin
          state    <= ST_PHY_WAIT;
          tst_wren <= 1'b0;
          tst_addr <= '0;
          tst_data <= '0;
        end
        ST_PHY_WAIT: begin
          if (t_zero) state <= ST_UTMI_WAIT;
        end
        ST_UTMI_WAIT: begin
          if (t_zero) begin
            state <= ST_UP;
            busy  <= 1'b0;
            done  <= 1'b1;
          end
        end
        ST_DN_POR: begin
          state   <= ST_DN_REF;
          por_rst <= 1'b1;
        end
        ST_DN_REF: begin
          state     <= ST_OFF;
          refclk_en <= 1'b0;
          busy      <= 1'b0;
        end
        default: state <= ST_OFF;
      endcase
    end
  end

endmodule

// File: rtl/usbphy_bringup_seq_chk.sv
module usbphy_bringup_seq_chk #(
  parameter int NPORT = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             refclk_en,
  input logic             por_rst,
  input logic [NPORT-1:0] utmi_rst,
  input logic [7:0]       tst_addr,
  input logic [7:0]       tst_data,
  input logic             tst_wren,
  input logic             tst_clk,
  input logic             busy,
  input logic             done
);

  AST_POR_NEEDS_REFCLK: assert property (@(posedge clk) disable iff (rst)
    !refclk_en |-> por_rst) else $error("por released without refclk"); // R2

  AST_STROBE_FIELDS: assert property (@(posedge clk) disable iff (rst)
    tst_clk |-> (tst_wren && tst_addr == 8'h06 && tst_data == 8'h04))
    else $error("strobe without write fields"); // R3

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    tst_clk |=> (!tst_clk && tst_wren)) else $error("strobe shape"); // R4

  AST_UTMI_NEEDS_POR: assert property (@(posedge clk) disable iff (rst)
    (utmi_rst != {NPORT{1'b1}}) |-> !por_rst) else $error("utmi before por"); // R5

  AST_DONE_EXCL_BUSY: assert property (@(posedge clk) disable iff (rst)
    !(done && busy)) else $error("done and busy"); // R6

  AST_DOWN_ORDER: assert property (@(posedge clk) disable iff (rst)
    $rose(por_rst) |-> (utmi_rst == {NPORT{1'b1}} && busy))
    else $error("por before utmi"); // R7

endmodule

bind usbphy_bringup_seq usbphy_bringup_seq_chk #(.NPORT(NPORT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .refclk_en (refclk_en),
  .por_rst   (por_rst),
  .utmi_rst  (utmi_rst),
  .tst_addr  (tst_addr),
  .tst_data  (tst_data),
  .tst_wren  (tst_wren),
  .tst_clk   (tst_clk),
  .busy      (busy),
  .done      (done)
);

// File: tb/usbphy_bringup_seq_bench.sv
module usbphy_bringup_seq_bench;

  localparam int C    = 2;
  localparam int DR   = 100 * C;
  localparam int DP   = 300 * C;
  localparam int DPH  = 2000 * C;
  localparam int DU   = 2000 * C;
  localparam int VW   = 24;

  typedef struct {
    int            cyc;
    logic [VW-1:0] vec;
    string         tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       init_req = 1'b0;
  logic       exit_req = 1'b0;
  logic [0:0] port_sel = '0;
  logic       refclk_en, por_rst, tst_wren, tst_clk, busy, done;
  logic [1:0] utmi_rst;
  logic [7:0] tst_addr, tst_data;

  always #2.5 clk = ~clk;

  usbphy_bringup_seq #(.CYCLES_PER_US(C)) u_usbphy_bringup_seq (
    .clk (clk), .rst (rst), .init_req (init_req), .exit_req (exit_req),
    .port_sel (port_sel), .refclk_en (refclk_en), .por_rst (por_rst),
    .utmi_rst (utmi_rst), .tst_addr (tst_addr), .tst_data (tst_data),
    .tst_wren (tst_wren), .tst_clk (tst_clk), .busy (busy), .done (done)
  );

  int cyc = 0;
  int nchk = 0;
  int nfail = 0;
  exp_t q[$];
  logic [VW-1:0] last_pushed;
  logic [VW-1:0] prev;
  logic mon_on = 1'b0;

  logic       m_ref = 1'b0, m_por = 1'b1, m_wren = 1'b0, m_clk = 1'b0;
  logic       m_busy = 1'b0, m_done = 1'b0;
  logic [1:0] m_utmi = 2'b11;
  logic [7:0] m_addr = '0, m_data = '0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [VW-1:0] pack_dut();
    return {refclk_en, por_rst, utmi_rst, tst_wren, tst_clk, tst_addr, tst_data, busy, done};
  endfunction

  function automatic logic [VW-1:0] pack_model();
    return {m_ref, m_por, m_utmi, m_wren, m_clk, m_addr, m_data, m_busy, m_done};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [VW-1:0] act,
                       input logic [VW-1:0] exp, input int acyc, input int ecyc);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h @%0d expected %h @%0d", tag, act, acyc, exp, ecyc);
    end
  endtask

  task automatic push(input int c, input string tag);
    logic [VW-1:0] v;
    v = pack_model();
    if (v != last_pushed) begin
      q.push_back('{cyc: c, vec: v, tag: tag});
      last_pushed = v;
    end
  endtask

  // Monitor: every output change is popped against the scoreboard.
  always @(negedge clk) begin
    if (mon_on) begin
      logic [VW-1:0] cur;
      exp_t it;
      cur = pack_dut();
      if (cur !== prev) begin
        if (q.size() == 0) begin
          check(1'b0, "R8 unexpected output change", cur, prev, cyc, -1);
        end else begin
          it = q.pop_front();
          check(cur === it.vec && cyc == it.cyc, it.tag, cur, it.vec, cyc, it.cyc);
        end
      end else if (q.size() > 0 && q[0].cyc < cyc) begin
        it = q.pop_front();
        check(1'b0, it.tag, cur, it.vec, cyc, it.cyc);
      end
      prev = cur;
    end
  end

  task automatic start_init(input int p, output int fin);
    int e0, t1;
    @(negedge clk);
    port_sel = p[0:0];
    init_req = 1'b1;
    e0 = cyc + 1;
    m_ref = 1'b1; m_busy = 1'b1;              push(e0, "R2 refclk on and busy");
    m_por = 1'b0;                             push(e0 + DR, "R2 por release timing");
    t1 = e0 + DR + DP;
    m_wren = 1'b1; m_addr = 8'h06; m_data = 8'h04; push(t1, "R3 write setup");
    m_clk = 1'b1;                             push(t1 + 1, "R4 strobe high");
    m_clk = 1'b0;                             push(t1 + 2, "R4 strobe low");
    m_wren = 1'b0; m_addr = '0; m_data = '0;  push(t1 + 3, "R4 write fields clear");
    m_utmi[p] = 1'b0;                         push(t1 + 3 + DPH, "R5 utmi release of port");
    m_busy = 1'b0; m_done = 1'b1;             push(t1 + 3 + DPH + DU, "R6 done and busy");
    fin = t1 + 3 + DPH + DU;
    @(negedge clk);
    init_req = 1'b0;
  endtask

  task automatic start_exit(input bit with_init, output int fin);
    int e0;
    @(negedge clk);
    exit_req = 1'b1;
    init_req = with_init;
    e0 = cyc + 1;
    m_utmi = 2'b11; m_done = 1'b0; m_busy = 1'b1; push(e0, "R7 exit accept");
    m_por = 1'b1;                                push(e0 + 1, "R7 por asserted");
    m_ref = 1'b0; m_busy = 1'b0;                 push(e0 + 2, "R7 refclk off");
    fin = e0 + 2;
    @(negedge clk);
    exit_req = 1'b0;
    init_req = 1'b0;
  endtask

  task automatic stray_pulse(input bit i, input bit e, input int p);
    @(negedge clk);
    init_req = i; exit_req = e; port_sel = p[0:0];
    @(negedge clk);
    init_req = 1'b0; exit_req = 1'b0;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c + 2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int fin;
    last_pushed = pack_model();
    repeat (4) @(negedge clk);
    // R1: reset values
    check(pack_dut() === pack_model(), "R1 reset state", pack_dut(), pack_model(), cyc, cyc);
    rst = 1'b0;
    @(negedge clk);
    check(pack_dut() === pack_model(), "R1 state after reset", pack_dut(), pack_model(), cyc, cyc);
    prev = pack_dut();
    mon_on = 1'b1;

    // Power up port 0, with stray requests mid-sequence (R8)
    start_init(0, fin);
    repeat (20) @(negedge clk);
    stray_pulse(1'b0, 1'b1, 1);
    repeat (DR) @(negedge clk);
    stray_pulse(1'b1, 1'b0, 1);
    wait_until(fin);

    // R9: init while done is ignored
    stray_pulse(1'b1, 1'b0, 1);
    repeat (10) @(negedge clk);

    // R7: full reverse order from up, with a stray init one cycle in (R8)
    start_exit(1'b0, fin);
    stray_pulse(1'b1, 1'b0, 0);
    wait_until(fin);

    // R7: exit from idle only pulses busy
    start_exit(1'b0, fin);
    wait_until(fin);

    // R5: power up port 1; port 0 must stay in reset
    start_init(1, fin);
    wait_until(fin);
    check(utmi_rst === 2'b01, "R5 other port held", {22'b0, utmi_rst}, 24'd1, cyc, cyc);

    // R9: init and exit together while idle: exit wins
    start_exit(1'b1, fin);
    wait_until(fin);
    start_exit(1'b1, fin);
    wait_until(fin);
    repeat (10) @(negedge clk);

    check(q.size() == 0, "R8 scoreboard drained", VW'(q.size()), '0, cyc, cyc);
    finish_run();
  end

endmodule